// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the digital supervisor of an on-chip clock generator. It decides which of five operating arrangements the generator is in: output stopped, oscillator free-running on its own trim, frequency loop closed on the internal reference, external clock passed straight through, or frequency loop closed on the external reference. Each closed-loop arrangement has a hunting sub-state, while the loop is still converging, and a held sub-state, once lock is reported. The analog oscillator and the frequency comparator sit outside the block. They feed it lock and reference-present flags, and the block returns the current state and the post-divider setting.

When the reference or the lock is lost while the loop is closed, the block records a sticky fault and raises either a one-cycle reset request or a level interrupt, as configured. It also adds one extra halving to the output divider so the system cannot be over-clocked while the oscillator drifts. The power-of-two divider setting and this penalty take effect only on a strobe marking an output clock edge. The oscillator control word is held in a register that keeps its value through stop and through reference loss, so the loop can relock from its last setting.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: Under synchronous reset, and on the first cycle after it, `state_o` is 1 (self-clocked), `clk_run` is 1, `div_shift` is 0, the fault outputs are 0 and `dco_word` equals the parameter `DCO_INIT`.
- R2: With `stop_req` high, the next edge puts `state_o` at 0 (off) and drops `clk_run`. Once `stop_req` is low, the next edge enters the mode named by `mode_req` (0 self-clocked, 1 internal loop, 2 external bypass, 3 external loop) as a fresh entry.
- R3: A closed-loop mode is always entered in its hunting state (2 for internal, 5 for external). It moves to its held state (3, 6) on the edge after `lock_det` is seen with its reference present. It returns to hunting when lock or the reference goes away.
- R4: Requesting the internal loop without `int_ref_ok`, or an external mode without `ext_ref_ok`, gives state 1 instead. A bypass whose external clock disappears also falls back to state 1.
- R5: `ext_path` is high exactly while `state_o` is 4 (bypass).
- R6: A loss of lock or of reference in a closed-loop mode adds 1 to `div_shift`. The extra 1 is removed only after the loop is back in its held state. Both changes appear one `out_edge` strobe after the state change.
- R7: `div_shift` follows the 3-bit `div_sel` (shift 0 to 7, ratio /1 to /128) only at an edge where `out_edge` is high. Without `out_edge`, `div_sel` has no effect.
- R8: With `fault_is_reset` high, a loss produces a `fault_rst_req` pulse of exactly one cycle, once per fault episode, and `fault_irq` stays low. With it low, `fault_irq` mirrors the sticky flag.
- R9: `fault_flag` is set on the edge that registers a loss and stays set until `fault_clr`. A new loss in the same cycle as `fault_clr` wins.
- R10: `dco_word` loads `dco_val` on `dco_ld` only in state 1 or in a closed-loop state whose reference is present. In all other states it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 0 self, 1 internal loop, 2 bypass, 3 external loop |
| stop_req | input | 1 | Stop request; holds output static |
| lock_det | input | 1 | Lock flag from the frequency comparator |
| int_ref_ok | input | 1 | Internal reference is running |
| ext_ref_ok | input | 1 | External reference is running |
| div_sel | input | DIV_W | Post-divider power-of-two select |
| fault_is_reset | input | 1 | 1: faults request reset, 0: faults interrupt |
| fault_clr | input | 1 | Clears the sticky fault flag |
| out_edge | input | 1 | Strobe marking an output clock edge |
| dco_ld | input | 1 | Load strobe for the oscillator control word |
| dco_val | input | DCO_W | New oscillator control word |
| state_o | output | 3 | Current state code (0 to 6) |
| clk_run | output | 1 | Output clock enabled (low in off state) |
| ext_path | output | 1 | External clock routed directly to output |
| div_shift | output | SH_W | Applied divide exponent including penalty |
| fault_rst_req | output | 1 | One-cycle reset request on a fault |
| fault_irq | output | 1 | Level interrupt for a recorded fault |
| fault_flag | output | 1 | Sticky fault status |
| dco_word | output | DCO_W | Retained oscillator control word |

## Verification
On every cycle the checker checks several things. Stop forces the off state and stops the clock on the next edge. A held state is reached only from its own hunting state with lock present, and bypass is only occupied with a live external clock. The applied divide exponent and the control word stay frozen unless their strobes fired, and a reset request never lasts two cycles. The bench scenarios are needed for the behaviour that depends on history. That covers the penalty appearing and later clearing on relock, fresh entry into hunting after stop, lockout when a reference is absent, and the sticky flag, including set-over-clear priority.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_SELF     = 3'd1,
        ST_INT_HUNT = 3'd2,
        ST_INT_HELD = 3'd3,
        ST_BYPASS   = 3'd4,
        ST_EXT_HUNT = 3'd5,
        ST_EXT_HELD = 3'd6
    } cg_state_e;

    typedef enum logic [1:0] {
        REQ_SELF   = 2'd0,
        REQ_INT    = 2'd1,
        REQ_BYPASS = 2'd2,
        REQ_EXT    = 2'd3
    } cg_req_e;

    typedef struct packed {
        cg_state_e nxt;
        logic      loss;
        logic      ref_ok;
    } cg_step_t;

    function automatic logic is_engaged(cg_state_e s);
        return (s == ST_INT_HUNT) || (s == ST_INT_HELD) ||
               (s == ST_EXT_HUNT) || (s == ST_EXT_HELD);
    endfunction

    function automatic logic is_held(cg_state_e s);
        return (s == ST_INT_HELD) || (s == ST_EXT_HELD);
    endfunction

    function automatic logic on_ext(cg_state_e s);
        return (s == ST_EXT_HUNT) || (s == ST_EXT_HELD) || (s == ST_BYPASS);
    endfunction

endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] mode_req,
    input  logic      stop_req,
    input  logic      lock_det,
    input  logic      int_ref_ok,
    input  logic      ext_ref_ok,
    input  logic      pen,
    output cg_state_e state,
    output cg_step_t  step
);

    cg_req_e   req;
    cg_state_e nxt;
    logic      cur_ref_ok;
    logic      same_family;

    assign req = cg_req_e'(mode_req);

    always_comb begin
        nxt = ST_SELF;
        if (stop_req) begin
            nxt = ST_OFF;
        end else begin
            unique case (req)
                REQ_SELF: nxt = ST_SELF;
                REQ_INT: begin
                    if (state == ST_INT_HUNT || state == ST_INT_HELD) begin
                        nxt = (lock_det && int_ref_ok) ? ST_INT_HELD : ST_INT_HUNT;
                    end else begin
                        nxt = int_ref_ok ? ST_INT_HUNT : ST_SELF;
                    end
                end
                REQ_BYPASS: nxt = ext_ref_ok ? ST_BYPASS : ST_SELF;
                REQ_EXT: begin
                    if (state == ST_EXT_HUNT || state == ST_EXT_HELD) begin
                        nxt = (lock_det && ext_ref_ok) ? ST_EXT_HELD : ST_EXT_HUNT;
                    end else begin
                        nxt = ext_ref_ok ? ST_EXT_HUNT : ST_SELF;
                    end
                end
                default: nxt = ST_SELF;
            endcase
        end
    end

    assign cur_ref_ok  = on_ext(state) ? ext_ref_ok : int_ref_ok;
    assign same_family = is_engaged(state) && is_engaged(nxt) &&
                         (on_ext(state) == on_ext(nxt));

    always_comb begin
        step.nxt    = nxt;
        step.ref_ok = cur_ref_ok;
        step.loss   = same_family && !pen &&
                      (!cur_ref_ok || (is_held(state) && !lock_det));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SELF;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/clkgen_fault.sv
module clkgen_fault
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cg_step_t  step,
    input  logic      fault_is_reset,
    input  logic      fault_clr,
    output logic      pen,
    output logic      fault_rst_req,
    output logic      fault_irq,
    output logic      fault_flag
);

    logic pen_n;

    always_comb begin
        if (!is_engaged(step.nxt)) begin
            pen_n = 1'b0;
        end else if (step.loss) begin
            pen_n = 1'b1;
        end else if (is_held(step.nxt)) begin
            pen_n = 1'b0;
        end else begin
            pen_n = pen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pen           <= 1'b0;
            fault_rst_req <= 1'b0;
            fault_flag    <= 1'b0;
        end else begin
            pen           <= pen_n;
            fault_rst_req <= step.loss && fault_is_reset;
            if (step.loss) begin
                fault_flag <= 1'b1;
            end else if (fault_clr) begin
                fault_flag <= 1'b0;
            end
        end
    end

    assign fault_irq = fault_flag && !fault_is_reset;

endmodule

// File: rtl/clkgen_div_sync.sv
module clkgen_div_sync #(
    parameter int DIV_W = 3,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_edge,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             pen,
    output logic [SH_W-1:0]  div_shift
);

    logic [DIV_W-1:0] div_q;
    logic             pen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            pen_q <= 1'b0;
        end else if (out_edge) begin
            div_q <= div_sel;
            pen_q <= pen;
        end
    end

    assign div_shift = SH_W'(div_q) + SH_W'(pen_q);

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int               DIV_W    = 3,
    parameter int               DCO_W    = 9,
    parameter logic [DCO_W-1:0] DCO_INIT = 9'h100,
    localparam int              SH_MAX   = (1 << DIV_W),
    localparam int              SH_W     = $clog2(SH_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_req,
    input  logic             stop_req,
    input  logic             lock_det,
    input  logic             int_ref_ok,
    input  logic             ext_ref_ok,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             fault_is_reset,
    input  logic             fault_clr,
    input  logic             out_edge,
    input  logic             dco_ld,
    input  logic [DCO_W-1:0] dco_val,
    output logic [2:0]       state_o,
    output logic             clk_run,
    output logic             ext_path,
    output logic [SH_W-1:0]  div_shift,
    output logic             fault_rst_req,
    output logic             fault_irq,
    output logic             fault_flag,
    output logic [DCO_W-1:0] dco_word
);

    cg_state_e state;
    cg_step_t  step;
    logic      pen;
    logic      load_ok;

    clkgen_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_req   (mode_req),
        .stop_req   (stop_req),
        .lock_det   (lock_det),
        .int_ref_ok (int_ref_ok),
        .ext_ref_ok (ext_ref_ok),
        .pen        (pen),
        .state      (state),
        .step       (step)
    );

    clkgen_fault u_fault (
        .clk            (clk),
        .rst            (rst),
        .step           (step),
        .fault_is_reset (fault_is_reset),
        .fault_clr      (fault_clr),
        .pen            (pen),
        .fault_rst_req  (fault_rst_req),
        .fault_irq      (fault_irq),
        .fault_flag     (fault_flag)
    );

    clkgen_div_sync #(.DIV_W(DIV_W), .SH_W(SH_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .out_edge  (out_edge),
        .div_sel   (div_sel),
        .pen       (pen),
        .div_shift (div_shift)
    );

    // Control word survives stop and reference loss.
    assign load_ok = (state == ST_SELF) || (is_engaged(state) && step.ref_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            dco_word <= DCO_INIT;
        end else if (dco_ld && load_ok) begin
            dco_word <= dco_val;
        end
    end

    assign state_o  = state;
    assign clk_run  = (state != ST_OFF);
    assign ext_path = (state == ST_BYPASS);

endmodule

// File: rtl/clkgen_mode_chk.sv
module clkgen_mode_chk #(
    parameter int DIV_W = 3,
    parameter int DCO_W = 9,
    parameter int SH_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req,
    input logic             lock_det,
    input logic             ext_ref_ok,
    input logic             out_edge,
    input logic             dco_ld,
    input logic [2:0]       state_o,
    input logic             clk_run,
    input logic [SH_W-1:0]  div_shift,
    input logic             fault_rst_req,
    input logic [DCO_W-1:0] dco_word
);

    // R2
    stop_to_off_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (state_o == 3'd0) && !clk_run);

    // R3
    held_from_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3) && !$past(state_o == 3'd3) |->
            $past(state_o == 3'd2) && $past(lock_det));

    // R4
    bypass_needs_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4) |-> $past(ext_ref_ok));

    // R7
    div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(out_edge) |-> $stable(div_shift));

    // R8
    rst_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_rst_req |=> !fault_rst_req);

    // R10
    dco_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dco_ld) |-> $stable(dco_word));

endmodule

bind clkgen_mode_ctrl clkgen_mode_chk #(.DIV_W(DIV_W), .DCO_W(DCO_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/clkgen_mode_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl_test;

    localparam int DIV_W = 3;
    localparam int DCO_W = 9;
    localparam int SH_W  = 4;
    localparam logic [DCO_W-1:0] DCO_INIT = 9'h100;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       mode_req;
    logic             stop_req, lock_det, int_ref_ok, ext_ref_ok;
    logic [DIV_W-1:0] div_sel;
    logic             fault_is_reset, fault_clr, out_edge, dco_ld;
    logic [DCO_W-1:0] dco_val;
    logic [2:0]       state_o;
    logic             clk_run, ext_path, fault_rst_req, fault_irq, fault_flag;
    logic [SH_W-1:0]  div_shift;
    logic [DCO_W-1:0] dco_word;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clkgen_mode_ctrl #(.DIV_W(DIV_W), .DCO_W(DCO_W), .DCO_INIT(DCO_INIT)) uut (.*);

    // fields: mode[9:8] stop[7] lock[6] int_ok[5] ext_ok[4] exp_state[3:1] exp_irq[0]
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b1},
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1},
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1},
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 3'd6, 1'b1},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 1'b1},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic defaults();
        mode_req = 2'd0; stop_req = 1'b0; lock_det = 1'b0;
        int_ref_ok = 1'b1; ext_ref_ok = 1'b1; div_sel = '0;
        fault_is_reset = 1'b0; fault_clr = 1'b0; out_edge = 1'b1;
        dco_ld = 1'b0; dco_val = '0;
    endtask

    task automatic do_reset();
        defaults();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 state", state_o, 3'd1);
        check("R1 clk_run", clk_run, 1'b1);
        check("R1 shift", div_shift, 0);
        check("R1 dco", dco_word, DCO_INIT);
        check("R1 flag", fault_flag, 1'b0);

        // table walk: R2 R3 R4 R5 state sequencing and R9 sticky interrupt
        for (int i = 0; i < NV; i++) begin
            mode_req   = VEC[i][9:8];
            stop_req   = VEC[i][7];
            lock_det   = VEC[i][6];
            int_ref_ok = VEC[i][5];
            ext_ref_ok = VEC[i][4];
            step();
            check($sformatf("R3/R4 row %0d state", i), state_o, VEC[i][3:1]);
            check($sformatf("R9 row %0d irq", i), fault_irq, VEC[i][0]);
            check($sformatf("R5 row %0d ext_path", i), ext_path, VEC[i][3:1] == 3'd4);
            if (VEC[i][3:1] == 3'd0) check("R2 clk_run off", clk_run, 1'b0);
        end

        // R9 clear, then set-over-clear priority
        fault_clr = 1'b1; step(); fault_clr = 1'b0;
        check("R9 cleared", fault_flag, 1'b0);

        // R6/R7 penalty divide tracking
        do_reset();
        div_sel = 3'd3; mode_req = 2'd1; lock_det = 1'b1;
        step(); step();
        check("R3 held", state_o, 3'd3);
        check("R7 shift=3", div_shift, 3);
        lock_det = 1'b0; step();
        check("R6 shift before strobe", div_shift, 3);
        step();
        check("R6 penalty on", div_shift, 4);
        lock_det = 1'b1; step();
        check("R6 penalty kept till held", div_shift, 4);
        step();
        check("R6 penalty off", div_shift, 3);

        // R7 strobe gating
        out_edge = 1'b0; div_sel = 3'd6;
        step(); step(); step();
        check("R7 no strobe", div_shift, 3);
        out_edge = 1'b1; step();
        check("R7 strobe applied", div_shift, 6);
        div_sel = 3'd7; step();
        check("R7 max ratio", div_shift, 7);

        // R8 reset-request mode
        fault_is_reset = 1'b1; lock_det = 1'b0; step();
        check("R8 rst_req", fault_rst_req, 1'b1);
        check("R8 irq low", fault_irq, 1'b0);
        check("R9 flag set", fault_flag, 1'b1);
        step();
        check("R8 one pulse", fault_rst_req, 1'b0);
        // R9 new loss wins over clear
        lock_det = 1'b1; step();
        lock_det = 1'b0; fault_clr = 1'b1; step(); fault_clr = 1'b0;
        check("R9 set wins", fault_flag, 1'b1);
        check("R8 second episode", fault_rst_req, 1'b1);

        // R10 control word retention
        do_reset();
        dco_ld = 1'b1; dco_val = 9'h0A5; step(); dco_ld = 1'b0;
        check("R10 load self", dco_word, 9'h0A5);
        stop_req = 1'b1; step();
        dco_ld = 1'b1; dco_val = 9'h033; step(); dco_ld = 1'b0;
        check("R10 kept in off", dco_word, 9'h0A5);
        stop_req = 1'b0; mode_req = 2'd1; step();
        int_ref_ok = 1'b0; dco_ld = 1'b1; dco_val = 9'h077; step(); dco_ld = 1'b0;
        check("R10 kept on ref loss", dco_word, 9'h0A5);
        check("R4 hunting keeps mode", state_o, 3'd2);
        int_ref_ok = 1'b1; dco_ld = 1'b1; dco_val = 9'h011; step(); dco_ld = 1'b0;
        check("R10 load engaged", dco_word, 9'h011);

        // R4 lockout from self
        mode_req = 2'd0; step();
        int_ref_ok = 1'b0; mode_req = 2'd1; step();
        check("R4 internal lockout", state_o, 3'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule